// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block narrows one IEEE-754 single-precision word to a half-precision word. A two-bit mode input chooses how inexact results are rounded: to nearest with ties to even, toward zero, toward positive infinity, or toward negative infinity. The sign bit passes straight through. The block looks only at the 31-bit magnitude to decide which result case applies, and it ORs the sign onto bit 15 of the code that case produces.

The magnitude falls into exactly one of five cases, and a priority classifier picks it:
- `CL_SPECIAL`: infinity or NaN.
- `CL_OVF`: too large for the half range.
- `CL_NORMAL`: a normal half result.
- `CL_SUBN`: a subnormal half result.
- `CL_UNDER`: below the smallest half subnormal.

The normal and subnormal cases share one rounding incrementer, and the carry out of that incrementer may ripple into the exponent field. The datapath is combinational up to a single output register. A word presented with `in_valid` therefore appears on `out_half` one clock later, with `out_valid` set.

Top module: `f2h_conv`

## Requirements
- R1: While synchronous active-high `rst` is high, `out_valid` and `out_half` are cleared to 0 at each clock edge, even if `in_valid` is high.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. When `in_valid` is low, `out_half` holds its previous value.
- R3: If the magnitude `in_word[30:0]` is above 0x7F800000, the result magnitude is 0x7E00. If it equals 0x7F800000, the result magnitude is 0x7C00.
- R4: A finite input whose exponent field is 143 or more overflows. The result magnitude depends on the mode:
  - nearest (mode 00): 0x7C00.
  - toward zero (01): 0x7BFF.
  - toward +inf (10): 0x7C00 when positive, 0x7BFF when negative.
  - toward −inf (11): 0x7BFF when positive, 0x7C00 when negative.
- R5: For an exponent field from 113 to 142, the truncated code is ((exp − 112) << 10) joined with input bits [22:13]. Mode 01 returns this code unchanged.
- R6: Mode 00 adds 1 to the truncated code when the dropped part is more than half an LSB. On an exact half it adds 1 only when the code's LSB is 1. A carry may ripple into the exponent, up to 0x7C00.
- R7: Mode 10 adds 1 to the truncated code of a positive value when any dropped bit is set. Mode 11 does the same for a negative value. Neither mode changes a value of the other sign.
- R8: For an exponent field from 102 to 112, the hidden bit is restored and the 24-bit significand is shifted right by (126 − exp) to give the code. The dropped bits are then rounded as in R5 to R7, and a carry may produce 0x0400.
- R9: Below exponent field 102, including zero and single-precision subnormal inputs, the result magnitude is 0. The exception is a nonzero magnitude under mode 10 with a positive sign, or under mode 11 with a negative sign, which gives 0x0001.
- R10: `out_half[15]` equals `in_word[31]` in every case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward −inf |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_half | output | 16 | Half-precision result |

## Verification
The bench builds the block with the default format parameters of the package: an 8-bit exponent and 23-bit fraction in, a 5-bit exponent and 10-bit fraction out. With these values every classifier threshold and every subnormal shift distance from 14 to 24 can be reached with exact words.

Directed words land on each threshold, on exact ties and on carries into the exponent. Random words are then drawn with the exponent concentrated between 95 and 150, so that the overflow, subnormal and underflow cases occur often under all four modes. A scoreboard compares every result against a reference model in the bench that rounds by comparing the dropped remainder with half an LSB.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
    // Format widths
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_MAN_W  = 23;
    localparam int HP_W      = 16;
    localparam int HP_EXP_W  = 5;
    localparam int HP_MAN_W  = 10;
    localparam int SP_BIAS   = 127;
    localparam int HP_BIAS   = 15;

    // Derived
    localparam int MAG_W        = SP_W - 1;
    localparam int HMAG_W       = HP_W - 1;
    localparam int SIG_W        = SP_MAN_W + 1;
    localparam int DROP_W       = SP_MAN_W - HP_MAN_W;
    localparam int SH_W         = $clog2(SIG_W + 1);
    localparam int NORM_MIN_EXP = SP_BIAS - HP_BIAS + 1;        // 113
    localparam int OVF_EXP      = SP_BIAS + HP_BIAS + 1;        // 143
    localparam int SUB_MIN_EXP  = NORM_MIN_EXP - HP_MAN_W - 1;  // 102
    localparam int SUB_SH_BASE  = NORM_MIN_EXP + DROP_W;        // 126

    localparam logic [MAG_W-1:0]  SP_INF_MAG = {{SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
    localparam logic [HMAG_W-1:0] H_INF      = {{HP_EXP_W{1'b1}}, {HP_MAN_W{1'b0}}};
    localparam logic [HMAG_W-1:0] H_QNAN     = {{HP_EXP_W{1'b1}}, 1'b1, {(HP_MAN_W-1){1'b0}}};
    localparam logic [HMAG_W-1:0] H_MAXFIN   = {{(HP_EXP_W-1){1'b1}}, 1'b0, {HP_MAN_W{1'b1}}};

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CL_SPECIAL,
        CL_OVF,
        CL_NORMAL,
        CL_SUBN,
        CL_UNDER
    } class_e;
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
    import f2h_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    output class_e           cls
);
    logic [SP_EXP_W-1:0] exp_f;
    assign exp_f = mag[MAG_W-1 -: SP_EXP_W];

    // Priority order matters: specials first, then falling magnitude.
    always_comb begin
        if (mag >= SP_INF_MAG)
            cls = CL_SPECIAL;
        else if (exp_f >= SP_EXP_W'(OVF_EXP))
            cls = CL_OVF;
        else if (exp_f >= SP_EXP_W'(NORM_MIN_EXP))
            cls = CL_NORMAL;
        else if (exp_f >= SP_EXP_W'(SUB_MIN_EXP))
            cls = CL_SUBN;
        else
            cls = CL_UNDER;
    end
endmodule

// File: rtl/f2h_align.sv
module f2h_align
    import f2h_pkg::*;
(
    input  logic [MAG_W-1:0]  mag,
    input  class_e            cls,
    output logic [HMAG_W-1:0] trunc,
    output logic              guard,
    output logic              sticky
);
    logic [SP_EXP_W-1:0] exp_f;
    logic [SP_MAN_W-1:0] man_f;
    logic [SIG_W-1:0]    sig;
    logic [SH_W-1:0]     sh;
    logic [SH_W-1:0]     gpos;
    logic [SIG_W-1:0]    gbits;
    logic [SIG_W-1:0]    below_mask;

    assign exp_f      = mag[MAG_W-1 -: SP_EXP_W];
    assign man_f      = mag[SP_MAN_W-1:0];
    assign sig        = {1'b1, man_f};
    assign sh         = SH_W'(SP_EXP_W'(SUB_SH_BASE) - exp_f);
    assign gpos       = sh - SH_W'(1);
    assign gbits      = sig >> gpos;
    assign below_mask = (SIG_W'(1) << gpos) - SIG_W'(1);

    always_comb begin
        trunc  = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        if (cls == CL_NORMAL) begin
            trunc  = {HP_EXP_W'(exp_f - SP_EXP_W'(NORM_MIN_EXP - 1)),
                      man_f[SP_MAN_W-1 -: HP_MAN_W]};
            guard  = man_f[DROP_W-1];
            sticky = |man_f[DROP_W-2:0];
        end else if (cls == CL_SUBN) begin
            trunc  = HMAG_W'(sig >> sh);
            guard  = gbits[0];
            sticky = |(sig & below_mask);
        end
    end
endmodule

// File: rtl/f2h_round.sv
module f2h_round
    import f2h_pkg::*;
(
    input  logic [HMAG_W-1:0] trunc,
    input  logic              guard,
    input  logic              sticky,
    input  logic              neg,
    input  rmode_e            mode,
    output logic [HMAG_W-1:0] rounded
);
    logic inc;

    always_comb begin
        unique case (mode)
            RM_NEAREST: inc = guard & (sticky | trunc[0]);
            RM_ZERO:    inc = 1'b0;
            RM_UP:      inc = ~neg & (guard | sticky);
            RM_DOWN:    inc =  neg & (guard | sticky);
        endcase
    end

    // Carry may ripple into the exponent field.
    assign rounded = trunc + HMAG_W'(inc);
endmodule

// File: rtl/f2h_conv.sv
module f2h_conv
    import f2h_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [SP_W-1:0] in_word,
    input  logic [1:0]    in_mode,
    output logic          out_valid,
    output logic [HP_W-1:0] out_half
);
    logic              sign;
    logic [MAG_W-1:0]  mag;
    rmode_e            mode;
    class_e            cls;
    logic [HMAG_W-1:0] trunc;
    logic              guard;
    logic              sticky;
    logic [HMAG_W-1:0] rounded;
    logic [HMAG_W-1:0] ovf_code;
    logic [HMAG_W-1:0] under_code;
    logic [HMAG_W-1:0] code;

    assign sign = in_word[SP_W-1];
    assign mag  = in_word[MAG_W-1:0];
    assign mode = rmode_e'(in_mode);

    f2h_classify u_classify (
        .mag (mag),
        .cls (cls)
    );

    f2h_align u_align (
        .mag    (mag),
        .cls    (cls),
        .trunc  (trunc),
        .guard  (guard),
        .sticky (sticky)
    );

    f2h_round u_round (
        .trunc   (trunc),
        .guard   (guard),
        .sticky  (sticky),
        .neg     (sign),
        .mode    (mode),
        .rounded (rounded)
    );

    // Saturation choice on overflow
    always_comb begin
        unique case (mode)
            RM_NEAREST: ovf_code = H_INF;
            RM_ZERO:    ovf_code = H_MAXFIN;
            RM_UP:      ovf_code = sign ? H_MAXFIN : H_INF;
            RM_DOWN:    ovf_code = sign ? H_INF : H_MAXFIN;
        endcase
    end

    // Underflow: a nonzero value rounded away from zero lands on the smallest subnormal
    always_comb begin
        under_code = '0;
        if (mag != '0) begin
            if ((mode == RM_UP && !sign) || (mode == RM_DOWN && sign))
                under_code = HMAG_W'(1);
        end
    end

    always_comb begin
        case (cls)
            CL_SPECIAL:        code = (mag > SP_INF_MAG) ? H_QNAN : H_INF;
            CL_OVF:            code = ovf_code;
            CL_NORMAL, CL_SUBN: code = rounded;
            default:           code = under_code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_half  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_half <= {sign, code};
        end
    end

    // R2: strobe tracks the input one clock later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_half));
    // R10: sign kept
    a_r10_sign_kept: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_half[HP_W-1] == $past(in_word[SP_W-1]));
    // R3: NaN becomes the quiet code
    a_r3_nan_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[MAG_W-1:0] > SP_INF_MAG) |=> out_half[HMAG_W-1:0] == H_QNAN);
    // R4: toward zero saturates to the largest finite
    a_r4_rtz_saturate: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01 && in_word[MAG_W-1 -: SP_EXP_W] >= SP_EXP_W'(OVF_EXP)
         && in_word[MAG_W-1:0] < SP_INF_MAG) |=> out_half[HMAG_W-1:0] == H_MAXFIN);
    // R9: zero magnitude stays zero
    a_r9_zero_stays_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[MAG_W-1:0] == '0) |=> out_half[HMAG_W-1:0] == '0);
endmodule

// File: tb/f2h_conv_bench.sv
`timescale 1ns/1ps
module f2h_conv_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [15:0] out_half;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] exp_val;
        logic [31:0] word;
        logic [1:0]  mode;
        string       req;
    } item_t;

    item_t       sb[$];
    logic [15:0] last_exp = '0;

    always #2 clk = ~clk;

    f2h_conv u_f2h_conv (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_half  (out_half)
    );

    // Reference: round by comparing the dropped remainder with half an LSB
    function automatic logic [15:0] ref_half(input logic [31:0] w, input logic [1:0] m);
        logic        s;
        int          e;
        longint      sig;
        longint      q;
        longint      rem;
        longint      halfu;
        int          sh;
        bit          up;
        logic [14:0] c;
        s = w[31];
        e = int'(w[30:23]);
        if (e == 255) begin
            c = (w[22:0] != 0) ? 15'h7E00 : 15'h7C00;
        end else if (e >= 143) begin
            case (m)
                2'b00: c = 15'h7C00;
                2'b01: c = 15'h7BFF;
                2'b10: c = s ? 15'h7BFF : 15'h7C00;
                default: c = s ? 15'h7C00 : 15'h7BFF;
            endcase
        end else if (e >= 102) begin
            sig   = longint'({1'b1, w[22:0]});
            sh    = (e >= 113) ? 13 : (126 - e);
            q     = sig >> sh;
            rem   = sig & ((64'd1 << sh) - 1);
            halfu = 64'd1 << (sh - 1);
            case (m)
                2'b00: up = (rem > halfu) || (rem == halfu && q[0]);
                2'b01: up = 0;
                2'b10: up = !s && rem != 0;
                default: up = s && rem != 0;
            endcase
            if (e >= 113) q = q + longint'((e - 113) << 10);
            c = 15'(q + longint'(up));
        end else if (w[30:0] == 0) begin
            c = '0;
        end else begin
            c = ((m == 2'b10 && !s) || (m == 2'b11 && s)) ? 15'd1 : 15'd0;
        end
        return {s, c};
    endfunction

    function automatic string req_of(input logic [31:0] w, input logic [1:0] m);
        int    e;
        string r;
        e = int'(w[30:23]);
        if (e == 255)      r = "R3";
        else if (e >= 143) r = "R4";
        else if (e >= 113) r = (m == 2'b00) ? "R6" : (m == 2'b01) ? "R5" : "R7";
        else if (e >= 102) r = "R8";
        else               r = "R9";
        if (w[31]) r = {r, "/R10"};
        return r;
    endfunction

    task automatic send(input logic [31:0] w, input logic [1:0] m);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_mode  = m;
        it.exp_val = ref_half(w, m);
        it.word    = w;
        it.mode    = m;
        it.req     = req_of(w, m);
        sb.push_back(it);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            if (sb.size() == 0) begin
                check(0, "R2 unexpected strobe", 32'(out_valid), 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                last_exp = it.exp_val;
                checks++;
                if (out_half !== it.exp_val) begin
                    fails++;
                    $display("FAIL %s: word %h mode %0d actual %h expected %h",
                             it.req, it.word, it.mode, out_half, it.exp_val);
                end
            end
        end
    end

    task automatic dir_all_modes(input logic [31:0] w);
        for (int m = 0; m < 4; m++) begin
            send(w, 2'(m));
            send(w | 32'h8000_0000, 2'(m));
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
        check(out_half == 16'h0, "R1 out_half in reset", 32'(out_half), 32'd0);
        rst = 1'b0;

        // R3 specials
        dir_all_modes(32'h7F80_0000);
        dir_all_modes(32'h7F80_0001);
        dir_all_modes(32'h7FC0_0000);
        // R4 overflow boundary and the largest finite
        dir_all_modes(32'h4780_0000);
        dir_all_modes(32'h7F7F_FFFF);
        // R6 tie at the top of the range carries into infinity
        dir_all_modes(32'h477F_F000);
        dir_all_modes(32'h477F_E000);
        // R5/R6 normal values and exact ties
        dir_all_modes(32'h3F80_0000);
        dir_all_modes(32'h3F80_1000);
        dir_all_modes(32'h3F80_3000);
        dir_all_modes(32'h3F80_1001);
        // R8 minimum normal and the subnormal edge carrying to 0x0400
        dir_all_modes(32'h3880_0000);
        dir_all_modes(32'h387F_FFFF);
        dir_all_modes(32'h3800_0000);
        dir_all_modes(32'h3300_0000);
        dir_all_modes(32'h3300_0001);
        // R9 underflow and zero
        dir_all_modes(32'h32FF_FFFF);
        dir_all_modes(32'h0000_0001);
        dir_all_modes(32'h0000_0000);
        go_idle();

        // R2: idle cycle lowers the strobe and holds the result
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle strobe", 32'(out_valid), 32'd0);
        check(out_half == last_exp, "R2 hold", 32'(out_half), 32'(last_exp));

        // Random pass, exponent focused near the thresholds
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 2 == 0) w[30:23] = 8'(95 + ($urandom % 56));
            send(w, 2'($urandom % 4));
            if (k % 97 == 0) go_idle();
        end
        go_idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2 results outstanding", 32'(sb.size()), 32'd0);

        // R1: reset with in_valid high clears the strobe
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_word = 32'h3F80_0000;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset overrides valid", 32'(out_valid), 32'd0);
        check(out_half == 16'h0, "R1 reset clears result", 32'(out_half), 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule